// File: doc/BRIEF.md
# Sound-CPU I/O Page Decoder with Boot-ROM Overlay

This block sits between a sound processor's byte-wide bus and the storage around it. It decodes the sixteen-byte I/O page at 0x00F0 to 0x00FF. Every access outside that page goes to the external RAM. Inside the page, each address selects one target: a test register, a control register, an index latch, a data window into a 128-entry sound register file, four communication port registers, two bytes that behave as plain RAM, or the timer slots. The block does not implement the timers. For the timer slots it only raises a strobe that carries a slot number.

A small boot ROM is built from a parameter vector and lies over the top 64 bytes of the address space. The overlay applies to reads only. A write to that range always reaches RAM, and the written byte can be read once the overlay is switched off. The control register holds the overlay enable and the timer enables, and it can clear either pair of port registers. The sound register file is reached in two steps: write an index to the latch, then access the data window, with a guard against out-of-range indices. Read data is registered.

Top module: `iopage_decoder`

## Requirements
- R1: A read at any address outside the I/O page and outside an active overlay returns the RAM byte on `cpu_rdata` one clock later. A write there asserts `ram_we` in the same cycle, with `ram_addr` equal to `cpu_addr`.
- R2: After reset the overlay is enabled. Control write bit 7 sets it and a 0 in bit 7 clears it. While it is enabled, reads of 0xFFC0–0xFFFF return ROM byte (address − 0xFFC0). Writes to that range always assert `ram_we`, so a byte written there reads back once the overlay is cleared. 0xFFBF is never overlaid.
- R3: A control write (0x00F1) with bit 4 set clears ports 0x00F4 and 0x00F5 to 0. With bit 5 set it clears ports 0x00F6 and 0x00F7 to 0. Ports whose clear bit is 0 keep their value.
- R4: Ports 0x00F4–0x00F7 are 0 after reset. Each one reads back the last value written to it or cleared into it.
- R5: 0x00F2 is a read/write index latch and is 0 after reset.
- R6: A read of 0x00F3 returns sound register (index & 0x7F). A write to 0x00F3 asserts `sreg_we` with `sreg_addr` = index only when index < 0x80. An index of 0x80 or higher leaves the register file unchanged.
- R7: Reads of 0x00F0 and 0x00F1 return 0. A write to 0x00F0 writes neither RAM nor the sound register file.
- R8: 0x00F8 and 0x00F9 are ordinary RAM bytes.
- R9: Bits 2:0 of a control write appear on `tmr_en` one clock later; `tmr_en` is 0 after reset. An access to 0x00FA–0x00FF raises `tmr_stb` in the same cycle, with `tmr_sel` = address − 0x00FA and `tmr_wr` marking a write. Reads of those slots return 0.
- R10: `cpu_rdata` is 0 after reset. It changes only on the clock after a read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | Read request this cycle |
| cpu_wr | input | 1 | Write request this cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| ram_addr | output | 16 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, combinational from `ram_addr` |
| sreg_addr | output | 7 | Sound register index |
| sreg_we | output | 1 | Sound register write enable |
| sreg_wdata | output | 8 | Sound register write data |
| sreg_rdata | input | 8 | Sound register read data, combinational |
| tmr_en | output | 3 | Timer enables from the control register |
| tmr_stb | output | 1 | Timer slot accessed |
| tmr_wr | output | 1 | The timer slot access is a write |
| tmr_sel | output | 3 | Timer slot number, 0 to 5 |

## Verification
The bench builds the block at its default geometry: a 16-bit address, an I/O page at 0x00F0, 64 overlay bytes and 128 sound registers. It overrides only the ROM contents, with a computed byte pattern that differs from the RAM pattern, so an overlay hit and a RAM read can be told apart at every overlay address. With this geometry the index guard falls on bit 7. The test indices 0x15 and 0x95 share their low seven bits, which exercises read masking and write suppression on the same register. The 0xFFBF/0xFFC0 pair tests the lower edge of the overlay.

// File: rtl/iopg_pkg.sv
package iopg_pkg;

   localparam int unsigned NUM_PORTS     = 4;
   localparam int unsigned CTRL_ROM_BIT  = 7;
   localparam int unsigned CTRL_CLR_BASE = 4;

   localparam logic [3:0] OFF_TEST = 4'h0;
   localparam logic [3:0] OFF_CTRL = 4'h1;
   localparam logic [3:0] OFF_IDX  = 4'h2;
   localparam logic [3:0] OFF_DATA = 4'h3;
   localparam logic [3:0] OFF_TMR0 = 4'hA;

   typedef enum logic [2:0] {
      T_RAM,
      T_TEST,
      T_CTRL,
      T_IDX,
      T_DATA,
      T_PORT,
      T_TMR
   } tgt_e;

   typedef struct packed {
      tgt_e       tgt;
      logic       in_rom;
      logic [2:0] sub;
   } dec_t;

endpackage

// File: rtl/iopg_decode.sv
module iopg_decode
   import iopg_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] IO_BASE   = 16'h00F0,
   parameter int unsigned       ROM_BYTES = 64
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   logic rom_hit;

   generate
      if (ROM_BYTES > 0) begin : g_rom_hit
         localparam logic [ADDR_W-1:0] ROM_BASE = ~ADDR_W'(ROM_BYTES - 1);
         assign rom_hit = (addr >= ROM_BASE);
      end else begin : g_no_rom
         assign rom_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      dec.tgt    = T_RAM;
      dec.sub    = '0;
      dec.in_rom = rom_hit;
      if (addr[ADDR_W-1:4] == IO_BASE[ADDR_W-1:4]) begin
         case (addr[3:0])
            OFF_TEST: dec.tgt = T_TEST;
            OFF_CTRL: dec.tgt = T_CTRL;
            OFF_IDX:  dec.tgt = T_IDX;
            OFF_DATA: dec.tgt = T_DATA;
            4'h4, 4'h5, 4'h6, 4'h7: begin
               dec.tgt = T_PORT;
               dec.sub = {1'b0, addr[1:0]};
            end
            4'h8, 4'h9: dec.tgt = T_RAM;
            default: begin
               dec.tgt = T_TMR;
               dec.sub = 3'(addr[3:0] - OFF_TMR0);
            end
         endcase
      end
   end

endmodule

// File: rtl/iopg_ctrl.sv
module iopg_ctrl
   import iopg_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_TIMERS = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr,
   input  tgt_e                             tgt,
   input  logic [1:0]                       psel,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_PORTS-1:0][DATA_W-1:0] port_q,
   output logic [DATA_W-1:0]                idx_q,
   output logic                             rom_en,
   output logic [NUM_TIMERS-1:0]            tmr_en
);

   logic ctrl_wr;
   logic idx_wr;
   logic port_wr;

   assign ctrl_wr = wr && (tgt == T_CTRL);
   assign idx_wr  = wr && (tgt == T_IDX);
   assign port_wr = wr && (tgt == T_PORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rom_en <= 1'b1;
         tmr_en <= '0;
      end else if (ctrl_wr) begin
         rom_en <= wdata[CTRL_ROM_BIT];
         tmr_en <= wdata[NUM_TIMERS-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (idx_wr)
         idx_q <= wdata;
   end

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         localparam int unsigned CLR_BIT = CTRL_CLR_BASE + (p / 2);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               port_q[p] <= '0;
            else if (ctrl_wr && wdata[CLR_BIT])
               port_q[p] <= '0;
            else if (port_wr && (psel == 2'(p)))
               port_q[p] <= wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/iopg_rom.sv
module iopg_rom #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ROM_BYTES = 64,
   parameter int unsigned ROM_AW    = 6,
   parameter logic [((ROM_BYTES > 0) ? ROM_BYTES : 1)*DATA_W-1:0] ROM_INIT = '0
) (
   input  logic [ROM_AW-1:0] idx,
   output logic [DATA_W-1:0] q
);

   generate
      if (ROM_BYTES > 0) begin : g_rom
         assign q = ROM_INIT[idx*DATA_W +: DATA_W];
      end else begin : g_empty
         assign q = '0;
      end
   endgenerate

endmodule

// File: rtl/iopage_decoder.sv
module iopage_decoder
   import iopg_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 16,
   parameter int unsigned       DATA_W     = 8,
   parameter logic [ADDR_W-1:0] IO_BASE    = 16'h00F0,
   parameter int unsigned       ROM_BYTES  = 64,
   parameter logic [((ROM_BYTES > 0) ? ROM_BYTES : 1)*DATA_W-1:0] ROM_INIT = '0,
   parameter int unsigned       SREG_DEPTH = 128,
   parameter int unsigned       NUM_TIMERS = 3,
   localparam int unsigned      SREG_AW    = $clog2(SREG_DEPTH),
   localparam int unsigned      ROM_AW     = (ROM_BYTES > 1) ? $clog2(ROM_BYTES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     cpu_addr,
   input  logic                  cpu_rd,
   input  logic                  cpu_wr,
   input  logic [DATA_W-1:0]     cpu_wdata,
   output logic [DATA_W-1:0]     cpu_rdata,
   output logic [ADDR_W-1:0]     ram_addr,
   output logic                  ram_we,
   output logic [DATA_W-1:0]     ram_wdata,
   input  logic [DATA_W-1:0]     ram_rdata,
   output logic [SREG_AW-1:0]    sreg_addr,
   output logic                  sreg_we,
   output logic [DATA_W-1:0]     sreg_wdata,
   input  logic [DATA_W-1:0]     sreg_rdata,
   output logic [NUM_TIMERS-1:0] tmr_en,
   output logic                  tmr_stb,
   output logic                  tmr_wr,
   output logic [2:0]            tmr_sel
);

   initial begin
      assert (DATA_W >= 8) else $fatal(1, "DATA_W must be at least 8");
      assert (IO_BASE[3:0] == 4'h0) else $fatal(1, "IO_BASE must be 16-byte aligned");
      assert (NUM_TIMERS >= 1 && NUM_TIMERS <= CTRL_CLR_BASE)
         else $fatal(1, "NUM_TIMERS out of range");
      assert (SREG_DEPTH >= 2 && (SREG_DEPTH & (SREG_DEPTH - 1)) == 0 && SREG_AW <= DATA_W)
         else $fatal(1, "SREG_DEPTH must be a power of two within the index width");
      assert (ROM_BYTES == 0 || ((ROM_BYTES & (ROM_BYTES - 1)) == 0 && ROM_AW < ADDR_W))
         else $fatal(1, "ROM_BYTES must be zero or a power of two");
   end

   dec_t                             dec;
   logic [NUM_PORTS-1:0][DATA_W-1:0] port_q;
   logic [DATA_W-1:0]                idx_q;
   logic                             rom_en;
   logic [DATA_W-1:0]                rom_q;
   logic                             idx_ok;
   logic [DATA_W-1:0]                rd_next;

   iopg_decode #(
      .ADDR_W   (ADDR_W),
      .IO_BASE  (IO_BASE),
      .ROM_BYTES(ROM_BYTES)
   ) u_decode (
      .addr(cpu_addr),
      .dec (dec)
   );

   iopg_ctrl #(
      .DATA_W    (DATA_W),
      .NUM_TIMERS(NUM_TIMERS)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cpu_wr),
      .tgt   (dec.tgt),
      .psel  (dec.sub[1:0]),
      .wdata (cpu_wdata),
      .port_q(port_q),
      .idx_q (idx_q),
      .rom_en(rom_en),
      .tmr_en(tmr_en)
   );

   iopg_rom #(
      .DATA_W   (DATA_W),
      .ROM_BYTES(ROM_BYTES),
      .ROM_AW   (ROM_AW),
      .ROM_INIT (ROM_INIT)
   ) u_rom (
      .idx(cpu_addr[ROM_AW-1:0]),
      .q  (rom_q)
   );

   generate
      if (SREG_AW < DATA_W) begin : g_guard
         assign idx_ok = ~|idx_q[DATA_W-1:SREG_AW];
      end else begin : g_full
         assign idx_ok = 1'b1;
      end
   endgenerate

   assign ram_addr   = cpu_addr;
   assign ram_wdata  = cpu_wdata;
   assign ram_we     = cpu_wr && (dec.tgt == T_RAM);

   assign sreg_addr  = idx_q[SREG_AW-1:0];
   assign sreg_wdata = cpu_wdata;
   assign sreg_we    = cpu_wr && (dec.tgt == T_DATA) && idx_ok;

   assign tmr_stb    = (cpu_rd || cpu_wr) && (dec.tgt == T_TMR);
   assign tmr_wr     = cpu_wr;
   assign tmr_sel    = dec.sub;

   always_comb begin
      case (dec.tgt)
         T_RAM:   rd_next = (dec.in_rom && rom_en) ? rom_q : ram_rdata;
         T_IDX:   rd_next = idx_q;
         T_DATA:  rd_next = sreg_rdata;
         T_PORT:  rd_next = port_q[dec.sub[1:0]];
         default: rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cpu_rdata <= '0;
      else if (cpu_rd)
         cpu_rdata <= rd_next;
   end

endmodule

// File: rtl/iopage_decoder_chk.sv
module iopage_decoder_chk
   import iopg_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 16,
   parameter int unsigned       DATA_W     = 8,
   parameter logic [ADDR_W-1:0] IO_BASE    = 16'h00F0,
   parameter int unsigned       ROM_BYTES  = 64,
   parameter int unsigned       NUM_TIMERS = 3
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [ADDR_W-1:0]                cpu_addr,
   input logic                             cpu_rd,
   input logic                             cpu_wr,
   input logic [DATA_W-1:0]                cpu_wdata,
   input logic [DATA_W-1:0]                cpu_rdata,
   input logic                             ram_we,
   input logic                             sreg_we,
   input logic [DATA_W-1:0]                sreg_wdata,
   input logic [NUM_TIMERS-1:0]            tmr_en,
   input logic [NUM_PORTS-1:0][DATA_W-1:0] port_q,
   input logic [DATA_W-1:0]                idx_q
);

   localparam logic [ADDR_W-1:0] A_TEST = IO_BASE;
   localparam logic [ADDR_W-1:0] A_CTRL = IO_BASE + ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_IDX  = IO_BASE + ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_DATA = IO_BASE + ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_P0   = IO_BASE + ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_G0   = IO_BASE + ADDR_W'(8);
   localparam logic [ADDR_W-1:0] A_G1   = IO_BASE + ADDR_W'(9);
   localparam logic [ADDR_W-1:0] TOP_A  = ~ADDR_W'((ROM_BYTES > 0) ? ROM_BYTES - 1 : 0);

   p_low_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr < IO_BASE) |-> ram_we);

   p_rom_wr_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && ROM_BYTES > 0 && cpu_addr >= TOP_A) |-> ram_we);

   p_clr_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == A_CTRL && cpu_wdata[CTRL_CLR_BASE])
      |=> (port_q[0] == '0 && port_q[1] == '0));

   p_clr_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == A_CTRL && cpu_wdata[CTRL_CLR_BASE+1])
      |=> (port_q[2] == '0 && port_q[3] == '0));

   p_port_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == A_P0) |=> (port_q[0] == $past(cpu_wdata)));

   p_idx_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == A_IDX) |=> (idx_q == $past(cpu_wdata)));

   p_sreg_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sreg_we |-> (cpu_wr && cpu_addr == A_DATA && sreg_wdata == cpu_wdata));

   p_zero_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && (cpu_addr == A_TEST || cpu_addr == A_CTRL)) |=> (cpu_rdata == '0));

   p_test_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == A_TEST) |-> (!ram_we && !sreg_we));

   p_gap_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && (cpu_addr == A_G0 || cpu_addr == A_G1)) |-> ram_we);

   p_tmr_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == A_CTRL) |=> (tmr_en == $past(cpu_wdata[NUM_TIMERS-1:0])));

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(cpu_rdata));

endmodule

bind iopage_decoder iopage_decoder_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .IO_BASE   (IO_BASE),
   .ROM_BYTES (ROM_BYTES),
   .NUM_TIMERS(NUM_TIMERS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .cpu_rd    (cpu_rd),
   .cpu_wr    (cpu_wr),
   .cpu_wdata (cpu_wdata),
   .cpu_rdata (cpu_rdata),
   .ram_we    (ram_we),
   .sreg_we   (sreg_we),
   .sreg_wdata(sreg_wdata),
   .tmr_en    (tmr_en),
   .port_q    (port_q),
   .idx_q     (idx_q)
);

// File: tb/tb_iopage_decoder.sv
module tb_iopage_decoder;

   function automatic logic [64*8-1:0] build_rom();
      logic [64*8-1:0] r;
      for (int i = 0; i < 64; i++) r[i*8 +: 8] = 8'(i * 7 + 5);
      return r;
   endfunction

   localparam logic [64*8-1:0] TB_ROM = build_rom();

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic [15:0] ram_addr;
   logic        ram_we;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata;
   logic [6:0]  sreg_addr;
   logic        sreg_we;
   logic [7:0]  sreg_wdata;
   logic [7:0]  sreg_rdata;
   logic [2:0]  tmr_en;
   logic        tmr_stb;
   logic        tmr_wr;
   logic [2:0]  tmr_sel;

   always #10 clk = ~clk;

   iopage_decoder #(.ROM_INIT(TB_ROM)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .sreg_addr(sreg_addr), .sreg_we(sreg_we), .sreg_wdata(sreg_wdata), .sreg_rdata(sreg_rdata),
      .tmr_en(tmr_en), .tmr_stb(tmr_stb), .tmr_wr(tmr_wr), .tmr_sel(tmr_sel)
   );

   logic [7:0] ram [1024];
   logic [7:0] exp_ram [1024];
   logic [7:0] sreg [128];
   logic [7:0] exp_sreg [128];

   initial begin
      for (int i = 0; i < 1024; i++) begin
         ram[i] = 8'(i) ^ 8'h5A;
         exp_ram[i] = 8'(i) ^ 8'h5A;
      end
      for (int i = 0; i < 128; i++) begin
         sreg[i] = 8'(i) + 8'h40;
         exp_sreg[i] = 8'(i) + 8'h40;
      end
   end

   always @(posedge clk) if (ram_we) ram[ram_addr[9:0]] <= ram_wdata;
   always @(posedge clk) if (sreg_we) sreg[sreg_addr] <= sreg_wdata;
   assign ram_rdata  = ram[ram_addr[9:0]];
   assign sreg_rdata = sreg[sreg_addr];

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   logic s_ram_we, s_sreg_we, s_stb, s_twr;
   logic [2:0] s_sel;

   task automatic check(input logic [7:0] act, input logic [7:0] expv, input string tag);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] expv, input string tag);
      @(negedge clk);
      cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      #1;
      s_stb = tmr_stb; s_sel = tmr_sel; s_twr = tmr_wr;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
      #1;
      s_ram_we = ram_we; s_sreg_we = sreg_we;
      s_stb = tmr_stb; s_sel = tmr_sel; s_twr = tmr_wr;
   endtask

   task automatic ram_wr(input logic [15:0] a, input logic [7:0] d);
      wr(a, d);
      exp_ram[a[9:0]] = d;
   endtask

   task automatic idle();
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
      #1;
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(posedge clk);
         if (cpu_rd && rst_n) begin
            @(negedge clk);
            check(cpu_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(cpu_rdata, 8'h00, "R10 rdata after reset");
      check({5'b0, tmr_en}, 8'h00, "R9 tmr_en after reset");
      rst_n = 1'b1;

      // R5 / R4 reset values
      rd(16'h00F2, 8'h00, "R5 index reset");
      rd(16'h00F4, 8'h00, "R4 port reset");

      // R1 plain RAM
      ram_wr(16'h0010, 8'h3C);
      check({7'b0, s_ram_we}, 8'h01, "R1 ram_we on low write");
      rd(16'h0010, 8'h3C, "R1 low ram readback");
      rd(16'h1234, exp_ram[10'h234], "R1 high ram read");

      // R8 gap bytes
      ram_wr(16'h00F8, 8'h77);
      check({7'b0, s_ram_we}, 8'h01, "R8 ram_we at F8");
      ram_wr(16'h00F9, 8'h88);
      rd(16'h00F8, 8'h77, "R8 F8 readback");
      rd(16'h00F9, 8'h88, "R8 F9 readback");

      // R2 overlay
      rd(16'hFFC0, TB_ROM[0*8 +: 8], "R2 rom first byte");
      rd(16'hFFFF, TB_ROM[63*8 +: 8], "R2 rom last byte");
      rd(16'hFFBF, exp_ram[10'h3BF], "R2 below overlay is ram");
      ram_wr(16'hFFC5, 8'h99);
      check({7'b0, s_ram_we}, 8'h01, "R2 ram_we under overlay");
      rd(16'hFFC5, TB_ROM[5*8 +: 8], "R2 overlay hides write");
      wr(16'h00F1, 8'h00);
      rd(16'hFFC5, 8'h99, "R2 ram visible after clear");
      wr(16'h00F1, 8'h80);
      rd(16'hFFC5, TB_ROM[5*8 +: 8], "R2 overlay re-enabled");

      // R4 ports and R3 clears
      wr(16'h00F4, 8'h11);
      wr(16'h00F5, 8'h22);
      wr(16'h00F6, 8'h33);
      wr(16'h00F7, 8'h44);
      rd(16'h00F5, 8'h22, "R4 port F5 readback");
      rd(16'h00F7, 8'h44, "R4 port F7 readback");
      wr(16'h00F1, 8'h90);
      rd(16'h00F4, 8'h00, "R3 lo clear F4");
      rd(16'h00F5, 8'h00, "R3 lo clear F5");
      rd(16'h00F6, 8'h33, "R3 hi kept F6");
      rd(16'h00F7, 8'h44, "R3 hi kept F7");
      wr(16'h00F4, 8'h55);
      wr(16'h00F1, 8'hA0);
      rd(16'h00F6, 8'h00, "R3 hi clear F6");
      rd(16'h00F7, 8'h00, "R3 hi clear F7");
      rd(16'h00F4, 8'h55, "R3 lo kept F4");

      // R5 / R6 index and data window
      wr(16'h00F2, 8'h15);
      rd(16'h00F2, 8'h15, "R5 index readback");
      wr(16'h00F3, 8'hAB);
      check({7'b0, s_sreg_we}, 8'h01, "R6 sreg_we in range");
      exp_sreg[7'h15] = 8'hAB;
      rd(16'h00F3, exp_sreg[7'h15], "R6 data window read");
      rd(16'h00F3 - 16'h0000, exp_sreg[7'h15], "R6 repeat read");
      wr(16'h00F2, 8'h95);
      rd(16'h00F3, exp_sreg[7'h15], "R6 read masks index bit 7");
      wr(16'h00F3, 8'hCD);
      check({7'b0, s_sreg_we}, 8'h00, "R6 write ignored at index 0x95");
      wr(16'h00F2, 8'h15);
      rd(16'h00F3, exp_sreg[7'h15], "R6 register unchanged");
      wr(16'h00F2, 8'h7F);
      rd(16'h00F3, exp_sreg[7'h7F], "R6 top index read");

      // R7 test and control read zero
      rd(16'h00F0, 8'h00, "R7 test reads zero");
      rd(16'h00F1, 8'h00, "R7 ctrl reads zero");
      wr(16'h00F0, 8'h55);
      check({6'b0, s_ram_we, s_sreg_we}, 8'h00, "R7 test write touches nothing");
      rd(16'h00F0, 8'h00, "R7 test still zero");

      // R9 timers
      wr(16'h00F1, 8'h85);
      idle();
      check({5'b0, tmr_en}, 8'h05, "R9 tmr_en from ctrl");
      wr(16'h00FB, 8'h10);
      check({4'b0, s_stb, s_sel}, 8'h09, "R9 strobe slot 1 write");
      check({7'b0, s_twr}, 8'h01, "R9 strobe marks write");
      check({7'b0, s_ram_we}, 8'h00, "R9 timer write not to ram");
      rd(16'h00FF, 8'h00, "R9 timer slot reads zero");
      check({4'b0, s_stb, s_sel}, 8'h0D, "R9 strobe slot 5 read");
      check({7'b0, s_twr}, 8'h00, "R9 read strobe not write");
      wr(16'h00F1, 8'h82);
      idle();
      check({5'b0, tmr_en}, 8'h02, "R9 tmr_en update");

      // R10 hold
      rd(16'h00F8, 8'h77, "R10 last read");
      idle();
      repeat (3) @(negedge clk);
      wr(16'h00F9, 8'hEE);
      idle();
      check(cpu_rdata, 8'h77, "R10 rdata held without read");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule